// File: doc/BRIEF.md
# Timing-Skew Calibration Controller

This block trims the sampling-clock delay of every channel in a time-interleaved converter while the converter keeps running. Each channel delivers signed output codes together with the two outputs of a pair of cross-coupled window comparators. A sample counts only when it is valid and both comparator outputs agree, which marks the input as near its zero crossing. For each channel the block adds up the magnitudes of the counted codes over a fixed number of counted samples. That sum is the skew metric. A well-aligned channel samples close to the zero crossing, so its metric is small.

At the end of each observation interval the channel compares its new metric with the one from the previous interval. If the metric did not grow, the delay keeps moving in the same direction. If it grew, the direction turns around. The delay then moves by one step. A coarse delay code is trimmed first. After a set number of consecutive turnarounds the channel locks the coarse code and hunts with a fine code instead. Each channel has its own accumulator and its own direction state. The search never stops, so the delays follow voltage and temperature drift.

Top module: `skew_cal_ctrl`

## Requirements
- R1: A sample of channel c is accepted only in a cycle where `smp_valid_i[c]` is 1 and `win_a_i[c]` equals `win_b_i[c]`. Samples with unequal comparator outputs, and cycles with valid low, leave the accumulated sum and the count unchanged.
- R2: Codes are 7-bit two's complement. The metric of an interval is the sum of the magnitudes of exactly OBS_LEN accepted codes. The code -64 counts as magnitude 63.
- R3: Delay codes are unsigned, and a larger value means more delay. The first decision after reset steps the active code upward by one.
- R4: At the end of each later interval, the direction is kept when the new metric is less than or equal to the previous metric. Otherwise the direction is inverted.
- R5: Each interval moves the active code by exactly one step. The step appears on the clock edge after the edge that accepts the interval's last sample. A code never changes at any other time.
- R6: The coarse code is trimmed first, and the fine code stays at mid-scale meanwhile. The step that completes REV_LIMIT consecutive direction inversions is applied to the coarse code. After that step the channel switches to the fine code, and the coarse code is frozen.
- R7: A step that would pass code 0 or the maximum code is taken in the opposite direction instead. That forced turnaround counts as a direction inversion.
- R8: Each channel's metric, direction and codes depend only on that channel's inputs.
- R9: After reset both codes of every channel are at mid-scale 2^(W-1), the direction is upward, and the coarse stage is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | NUM_CH | Per-channel sample strobe |
| smp_code_i | input | NUM_CH*CODE_W | Per-channel signed output code, channel c at bits [c*CODE_W +: CODE_W] |
| win_a_i | input | NUM_CH | First window comparator output per channel |
| win_b_i | input | NUM_CH | Second window comparator output per channel |
| coarse_dly_o | output | NUM_CH*COARSE_W | Coarse delay code per channel |
| fine_dly_o | output | NUM_CH*FINE_W | Fine delay code per channel |

## Verification
The bench builds the block with five channels, an observation interval of 4 accepted samples, 3-bit coarse and fine codes and a turnaround limit of 2. The short interval lets a dozen decisions run in a few hundred cycles. The 3-bit codes put both code limits within a few steps of mid-scale, so the forced turnaround shows up in both stages. The limit of 2 makes the coarse-to-fine switch happen early in the run. Positive and negative codes, rejected out-of-window samples, the saturated magnitude of -64 and idle channels are mixed into the same sequence.

// File: rtl/skew_cal_pkg.sv
package skew_cal_pkg;
  typedef enum logic { DIR_DOWN = 1'b0, DIR_UP = 1'b1 } dir_e;
  typedef enum logic { STG_COARSE = 1'b0, STG_FINE = 1'b1 } stage_e;
endpackage

// File: rtl/skew_win_accum.sv
module skew_win_accum #(
  parameter int CODE_W  = 7,
  parameter int OBS_LEN = 1024,
  localparam int MAG_MAX = (1 << (CODE_W - 1)) - 1,
  localparam int ACC_W   = $clog2(OBS_LEN * MAG_MAX + 1),
  localparam int CNT_W   = (OBS_LEN > 1) ? $clog2(OBS_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              win_a_i,
  input  logic              win_b_i,
  output logic              done_o,
  output logic [ACC_W-1:0]  metric_o
);
  logic              accept;
  logic [CODE_W-1:0] mag;
  logic [ACC_W-1:0]  acc_q, acc_sum;
  logic [CNT_W-1:0]  cnt_q;
  logic              last;

  assign accept = valid_i && (win_a_i == win_b_i);

  // magnitude of a two's complement code, most negative value clipped
  always_comb begin
    if (!code_i[CODE_W-1])                         mag = code_i;
    else if (code_i == {1'b1, {(CODE_W-1){1'b0}}}) mag = CODE_W'(MAG_MAX);
    else                                           mag = -code_i;
  end

  assign acc_sum = acc_q + ACC_W'(mag);
  assign last    = (cnt_q == CNT_W'(OBS_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
      metric_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        if (last) begin
          metric_o <= acc_sum;
          done_o   <= 1'b1;
          acc_q    <= '0;
          cnt_q    <= '0;
        end else begin
          acc_q <= acc_sum;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_hold_no_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> ($stable(acc_q) && $stable(cnt_q) && !done_o));

  assert_end_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (acc_q == '0 && cnt_q == '0));
endmodule

// File: rtl/skew_dir_stepper.sv
module skew_dir_stepper
  import skew_cal_pkg::*;
#(
  parameter int METRIC_W  = 16,
  parameter int COARSE_W  = 4,
  parameter int FINE_W    = 4,
  parameter int REV_LIMIT = 4,
  localparam int REV_W = $clog2(REV_LIMIT + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic [METRIC_W-1:0] metric_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o
);
  localparam logic [COARSE_W-1:0] C_MID = {1'b1, {(COARSE_W-1){1'b0}}};
  localparam logic [FINE_W-1:0]   F_MID = {1'b1, {(FINE_W-1){1'b0}}};
  localparam logic [COARSE_W-1:0] C_MAX = '1;
  localparam logic [FINE_W-1:0]   F_MAX = '1;

  dir_e                dir_q, dir_dec, dir_eff;
  stage_e              stage_q;
  logic [METRIC_W-1:0] prev_q;
  logic                have_prev_q;
  logic [REV_W-1:0]    rev_q, rev_nxt;
  logic                at_lim, reversed, to_fine;

  always_comb begin
    dir_dec = dir_q;
    if (have_prev_q && metric_i > prev_q) dir_dec = (dir_q == DIR_UP) ? DIR_DOWN : DIR_UP;
    if (stage_q == STG_FINE)
      at_lim = (dir_dec == DIR_UP) ? (fine_o == F_MAX) : (fine_o == '0);
    else
      at_lim = (dir_dec == DIR_UP) ? (coarse_o == C_MAX) : (coarse_o == '0);
    dir_eff  = at_lim ? ((dir_dec == DIR_UP) ? DIR_DOWN : DIR_UP) : dir_dec;
    reversed = (dir_eff != dir_q);
    if (!reversed)                            rev_nxt = '0;
    else if (rev_q == REV_W'(REV_LIMIT))      rev_nxt = rev_q;
    else                                      rev_nxt = rev_q + 1'b1;
    to_fine = (stage_q == STG_COARSE) && reversed && (rev_nxt >= REV_W'(REV_LIMIT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q       <= DIR_UP;
      stage_q     <= STG_COARSE;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      rev_q       <= '0;
      coarse_o    <= C_MID;
      fine_o      <= F_MID;
    end else if (done_i) begin
      dir_q       <= dir_eff;
      prev_q      <= metric_i;
      have_prev_q <= 1'b1;
      if (stage_q == STG_FINE) begin
        fine_o <= (dir_eff == DIR_UP) ? fine_o + 1'b1 : fine_o - 1'b1;
        rev_q  <= rev_nxt;
      end else begin
        coarse_o <= (dir_eff == DIR_UP) ? coarse_o + 1'b1 : coarse_o - 1'b1;
        rev_q    <= to_fine ? '0 : rev_nxt;
        if (to_fine) stage_q <= STG_FINE;
      end
    end
  end

  assert_step_needs_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(done_i) |-> ($stable(coarse_o) && $stable(fine_o)));

  assert_one_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_i) |-> ($countones({coarse_o != $past(coarse_o), fine_o != $past(fine_o)}) == 1));

  assert_fine_mid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == STG_COARSE) |-> (fine_o == F_MID));

  assert_coarse_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == STG_FINE && $past(stage_q) == STG_FINE) |-> $stable(coarse_o));
endmodule

// File: rtl/skew_cal_ctrl.sv
module skew_cal_ctrl #(
  parameter int NUM_CH    = 5,
  parameter int CODE_W    = 7,
  parameter int OBS_LEN   = 1024,
  parameter int COARSE_W  = 4,
  parameter int FINE_W    = 4,
  parameter int REV_LIMIT = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0]          smp_valid_i,
  input  logic [NUM_CH*CODE_W-1:0]   smp_code_i,
  input  logic [NUM_CH-1:0]          win_a_i,
  input  logic [NUM_CH-1:0]          win_b_i,
  output logic [NUM_CH*COARSE_W-1:0] coarse_dly_o,
  output logic [NUM_CH*FINE_W-1:0]   fine_dly_o
);
  localparam int MAG_MAX = (1 << (CODE_W - 1)) - 1;
  localparam int ACC_W   = $clog2(OBS_LEN * MAG_MAX + 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             done;
    logic [ACC_W-1:0] metric;

    skew_win_accum #(
      .CODE_W (CODE_W),
      .OBS_LEN(OBS_LEN)
    ) u_accum (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (smp_valid_i[c]),
      .code_i  (smp_code_i[c*CODE_W +: CODE_W]),
      .win_a_i (win_a_i[c]),
      .win_b_i (win_b_i[c]),
      .done_o  (done),
      .metric_o(metric)
    );

    skew_dir_stepper #(
      .METRIC_W (ACC_W),
      .COARSE_W (COARSE_W),
      .FINE_W   (FINE_W),
      .REV_LIMIT(REV_LIMIT)
    ) u_step (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .done_i  (done),
      .metric_i(metric),
      .coarse_o(coarse_dly_o[c*COARSE_W +: COARSE_W]),
      .fine_o  (fine_dly_o[c*FINE_W +: FINE_W])
    );
  end
endmodule

// File: tb/skew_cal_ctrl_test.sv
module skew_cal_ctrl_test;
  localparam int NUM_CH = 5, CODE_W = 7, OBS_LEN = 4, CW = 3, FW = 3, RL = 2;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [NUM_CH-1:0]    valid = '0;
  logic [NUM_CH*CODE_W-1:0] code = '0;
  logic [NUM_CH-1:0]    wa = '0, wb = '0;
  logic [NUM_CH*CW-1:0] coarse;
  logic [NUM_CH*FW-1:0] fine;
  int n_run = 0, n_fail = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  skew_cal_ctrl #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .OBS_LEN(OBS_LEN),
                  .COARSE_W(CW), .FINE_W(FW), .REV_LIMIT(RL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .smp_valid_i(valid), .smp_code_i(code),
    .win_a_i(wa), .win_b_i(wb), .coarse_dly_o(coarse), .fine_dly_o(fine));

  // vectors: magnitude per interval, expected coarse, expected fine (channel 0)
  localparam int VEC [12][3] = '{
    '{10,5,4}, '{8,6,4}, '{8,7,4}, '{5,6,4}, '{9,7,4}, '{9,7,5},
    '{12,7,4}, '{3,7,3}, '{3,7,2}, '{3,7,1}, '{3,7,0}, '{3,7,1}};

  task automatic chk(input int got, input int exp, input string req);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int c_of(input int ch); return int'(coarse[ch*CW +: CW]); endfunction
  function automatic int f_of(input int ch); return int'(fine[ch*FW +: FW]); endfunction

  task automatic put(input int ch, input int v, input bit vld, input bit inwin);
    valid[ch] = vld;
    code[ch*CODE_W +: CODE_W] = CODE_W'(v);
    wa[ch] = 1'b1;
    wb[ch] = inwin;
    @(negedge clk);
    valid[ch] = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // one interval of OBS_LEN accepted samples with rejected samples mixed in
  task automatic interval(input int ch, input int mag);
    for (int i = 0; i < OBS_LEN; i++) begin
      put(ch, -64, 1'b1, 1'b0);
      put(ch, 63, 1'b0, 1'b1);
      put(ch, (i % 2) ? -mag : mag, 1'b1, 1'b1);
    end
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9: reset state
    for (int ch = 0; ch < NUM_CH; ch++) begin
      chk(c_of(ch), 4, "R9 coarse mid");
      chk(f_of(ch), 4, "R9 fine mid");
    end
    // R1 R2 R3 R4 R5 R6 R7: vector walk on channel 0
    for (int k = 0; k < 12; k++) begin
      interval(0, VEC[k][0]);
      chk(c_of(0), VEC[k][1], $sformatf("R4 R6 R7 coarse vec %0d", k));
      chk(f_of(0), VEC[k][2], $sformatf("R4 R6 R7 fine vec %0d", k));
    end
    // R8: untouched channels stay at mid
    for (int ch = 1; ch < NUM_CH; ch++) chk(c_of(ch), 4, "R8 idle channel");
    // R2: -64 saturates to magnitude 63
    interval(1, 63);
    chk(c_of(1), 5, "R3 first step up");
    interval(1, 64);
    chk(c_of(1), 6, "R2 saturated magnitude keeps direction");
    // R1: rejected samples do not complete an interval
    for (int i = 0; i < OBS_LEN - 1; i++) put(2, 5, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) put(2, 5, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) put(2, 5, 1'b0, 1'b1);
    settle();
    chk(c_of(2), 4, "R1 rejected samples ignored");
    // R5: the step lands one edge after the last accepted sample
    valid[2] = 1'b1; code[2*CODE_W +: CODE_W] = 7'd5; wa[2] = 1'b0; wb[2] = 1'b0;
    @(negedge clk);
    valid[2] = 1'b0;
    chk(c_of(2), 4, "R5 no step at accept edge");
    @(negedge clk);
    chk(c_of(2), 5, "R5 step one edge later");
    chk(c_of(0), 7, "R8 channel 0 unaffected");
    chk(f_of(0), 1, "R8 channel 0 fine unaffected");
    // R9: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(c_of(0), 4, "R9 coarse after reset");
    chk(f_of(0), 4, "R9 fine after reset");
    chk(c_of(1), 4, "R9 coarse ch1 after reset");
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule